// File: doc/BRIEF.md
# Eight-Bit ALU with Zero and Carry Flags

This block is the execution unit of a small 8-bit soft controller. Each cycle it takes an operation code and a first operand. It also takes a second operand, picked from either a register value or an 8-bit immediate. It returns the 8-bit result in the same cycle. The operations cover pass-through (load), bitwise logic, add and subtract with or without a carry or borrow chain, and ten single-bit shift and rotate forms.

Two status flags, ZERO and CARRY, live inside the block. They update on the clock edge when the caller's flag-write enable is high and the operation affects flags. The registered CARRY is the carry or borrow input for the chained operations and for the shift forms that insert the carry. The block also reports two things: whether the selected operation produces a result to write back, and whether it updates the flags.

Top module: `alu8_core`

## Requirements
- R1: With use_imm_i high the second operand is imm_i, otherwise reg_b_i.
- R2: While rst_ni is low, zero_o and carry_o are 0.
- R3: Op codes: 0 load (result = second operand), 1 AND, 2 OR, 3 XOR, each producing the bitwise result in the same cycle.
- R4: Load (op 0) leaves zero_o and carry_o unchanged, and flag_we_o is low for it.
- R5: AND, OR and XOR clear CARRY when flags are written.
- R6: Op 4 adds; op 5 adds plus CARRY. The new CARRY is the carry out of bit 7.
- R7: Op 6 subtracts; op 7 subtracts the second operand and CARRY. The new CARRY is 1 exactly when a borrow occurs.
- R8: Right shifts by one bit, taking the first operand. Op 8 inserts 0 at bit 7, op 9 inserts 1, op 10 copies bit 7, op 11 inserts CARRY, and op 12 rotates bit 0 into bit 7. The new CARRY is the old bit 0.
- R9: Left shifts by one bit, taking the first operand. Op 13 inserts 0 at bit 0, op 14 inserts 1, op 15 copies bit 0, op 16 inserts CARRY, and op 17 rotates bit 7 into bit 0. The new CARRY is the old bit 7.
- R10: Every flag-updating operation sets ZERO to 1 exactly when its 8-bit result is 0x00.
- R11: With flag_we_i low, the flags keep their values.
- R12: Op codes 18 to 31 drive res_we_o and flag_we_o low and leave the flags unchanged. Ops 0 to 17 drive res_we_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand; also the shift and rotate source |
| reg_b_i | input | 8 | Second operand, register source |
| imm_i | input | 8 | Second operand, immediate source |
| use_imm_i | input | 1 | Selects imm_i as the second operand |
| flag_we_i | input | 1 | Permits a flag update this cycle |
| result_o | output | 8 | Result, combinational |
| res_we_o | output | 1 | Operation yields a result to write |
| flag_we_o | output | 1 | Operation updates the flags |
| zero_o | output | 1 | Registered ZERO flag |
| carry_o | output | 1 | Registered CARRY flag |

## Verification
The bench first sets CARRY to a chosen value and then runs each operation, so it catches these faults:
- a chained add or subtract that ignores the carry input, which gives results that are off by one;
- a subtract that reports carry-out instead of borrow, which inverts CARRY;
- shift forms whose fill bits are swapped, which gives wrong edge bits.

It also applies results of exactly 0x00, which catch a ZERO flag taken from the wrong operand. A load must not touch the flags, flags must hold with the enable low, and undefined codes must not write anything. A design that clobbered the flags in these cases would corrupt later branch decisions.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 5'd0,  OP_AND  = 5'd1,  OP_OR   = 5'd2,  OP_XOR  = 5'd3,
    OP_ADD  = 5'd4,  OP_ADDC = 5'd5,  OP_SUB  = 5'd6,  OP_SUBC = 5'd7,
    OP_SR0  = 5'd8,  OP_SR1  = 5'd9,  OP_SRX  = 5'd10, OP_SRC  = 5'd11,
    OP_RR   = 5'd12, OP_SL0  = 5'd13, OP_SL1  = 5'd14, OP_SLX  = 5'd15,
    OP_SLC  = 5'd16, OP_RL   = 5'd17
  } alu_op_e;

  localparam logic [OP_W-1:0] OP_LAST = OP_RL;
endpackage

// File: rtl/alu8_logic_arith.sv
module alu8_logic_arith
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            cin_i,
  output logic [DW-1:0]   res_o,
  output logic            cout_o,
  output logic            hit_o
);
  logic [DW:0] wide;

  always_comb begin
    wide   = '0;
    hit_o  = 1'b1;
    cout_o = 1'b0;
    unique case (op_i)
      OP_LOAD: wide = {1'b0, b_i};
      OP_AND:  wide = {1'b0, a_i & b_i};
      OP_OR:   wide = {1'b0, a_i | b_i};
      OP_XOR:  wide = {1'b0, a_i ^ b_i};
      OP_ADD:  wide = {1'b0, a_i} + {1'b0, b_i};
      OP_ADDC: wide = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
      OP_SUB:  wide = {1'b0, a_i} - {1'b0, b_i};
      OP_SUBC: wide = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin_i};
      default: hit_o = 1'b0;
    endcase
    // bit DW is carry for add, borrow for subtract, 0 for logic
    cout_o = wide[DW];
    res_o  = wide[DW-1:0];
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   a_i,
  input  logic            cin_i,
  output logic [DW-1:0]   res_o,
  output logic            cout_o,
  output logic            hit_o
);
  logic fill;
  logic right;

  always_comb begin
    hit_o = 1'b1;
    right = 1'b1;
    fill  = 1'b0;
    unique case (op_i)
      OP_SR0: fill = 1'b0;
      OP_SR1: fill = 1'b1;
      OP_SRX: fill = a_i[DW-1];
      OP_SRC: fill = cin_i;
      OP_RR:  fill = a_i[0];
      OP_SL0: begin right = 1'b0; fill = 1'b0; end
      OP_SL1: begin right = 1'b0; fill = 1'b1; end
      OP_SLX: begin right = 1'b0; fill = a_i[0]; end
      OP_SLC: begin right = 1'b0; fill = cin_i; end
      OP_RL:  begin right = 1'b0; fill = a_i[DW-1]; end
      default: hit_o = 1'b0;
    endcase
    if (right) begin
      res_o  = {fill, a_i[DW-1:1]};
      cout_o = a_i[0];
    end else begin
      res_o  = {a_i[DW-2:0], fill};
      cout_o = a_i[DW-1];
    end
  end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic zero_i,
  input  logic carry_i,
  output logic zero_o,
  output logic carry_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_o  <= 1'b0;
      carry_o <= 1'b0;
    end else if (upd_i) begin
      zero_o  <= zero_i;
      carry_o <= carry_i;
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   reg_b_i,
  input  logic [DW-1:0]   imm_i,
  input  logic            use_imm_i,
  input  logic            flag_we_i,
  output logic [DW-1:0]   result_o,
  output logic            res_we_o,
  output logic            flag_we_o,
  output logic            zero_o,
  output logic            carry_o
);
  logic [DW-1:0] b_sel, la_res, sh_res;
  logic          la_cout, sh_cout, la_hit, sh_hit, new_carry;

  assign b_sel = use_imm_i ? imm_i : reg_b_i;

  alu8_logic_arith #(.DW(DW)) u_la (
    .op_i(op_i), .a_i(a_i), .b_i(b_sel), .cin_i(carry_o),
    .res_o(la_res), .cout_o(la_cout), .hit_o(la_hit)
  );

  alu8_shift #(.DW(DW)) u_sh (
    .op_i(op_i), .a_i(a_i), .cin_i(carry_o),
    .res_o(sh_res), .cout_o(sh_cout), .hit_o(sh_hit)
  );

  always_comb begin
    result_o  = '0;
    new_carry = 1'b0;
    if (la_hit) begin
      result_o  = la_res;
      new_carry = la_cout;
    end else if (sh_hit) begin
      result_o  = sh_res;
      new_carry = sh_cout;
    end
  end

  assign res_we_o  = la_hit | sh_hit;
  assign flag_we_o = res_we_o && (op_i != OP_LOAD);

  alu8_flag_reg u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(flag_we_i && flag_we_o),
    .zero_i(result_o == '0), .carry_i(new_carry),
    .zero_o(zero_o), .carry_o(carry_o)
  );

  a_r4_load_holds_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOAD) |=> $stable({zero_o, carry_o}));

  a_r5_logic_clears_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)) |=> !carry_o);

  a_r8_right_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i >= OP_SR0 && op_i <= OP_RR) |=> (carry_o == $past(a_i[0])));

  a_r9_left_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i >= OP_SL0 && op_i <= OP_RL) |=> (carry_o == $past(a_i[DW-1])));

  a_r10_zero_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && flag_we_o) |=> (zero_o == ($past(result_o) == '0)));

  a_r11_hold_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable({zero_o, carry_o}));

  a_r12_invalid_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > OP_LAST) |-> (!res_we_o && !flag_we_o));
endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
  import alu8_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op = 5'd0;
  logic [7:0] a = 8'h00, reg_b = 8'h00, imm = 8'h00;
  logic       use_imm = 1'b0, flag_we = 1'b0;
  logic [7:0] result;
  logic       res_we, flag_we_out, zero, carry;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  alu8_core uut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .reg_b_i(reg_b),
    .imm_i(imm), .use_imm_i(use_imm), .flag_we_i(flag_we),
    .result_o(result), .res_we_o(res_we), .flag_we_o(flag_we_out),
    .zero_o(zero), .carry_o(carry)
  );

  // op, a, b, carry in, expected result, expected carry
  localparam logic [30:0] VEC [0:22] = '{
    {OP_LOAD, 8'h00, 8'h5A, 1'b1, 8'h5A, 1'b1},
    {OP_AND,  8'hF0, 8'h3C, 1'b1, 8'h30, 1'b0},
    {OP_OR,   8'hF0, 8'h0F, 1'b1, 8'hFF, 1'b0},
    {OP_XOR,  8'hAA, 8'hAA, 1'b1, 8'h00, 1'b0},
    {OP_ADD,  8'hFF, 8'h01, 1'b0, 8'h00, 1'b1},
    {OP_ADD,  8'h12, 8'h34, 1'b1, 8'h46, 1'b0},
    {OP_ADDC, 8'h12, 8'h34, 1'b1, 8'h47, 1'b0},
    {OP_ADDC, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1},
    {OP_SUB,  8'h05, 8'h07, 1'b0, 8'hFE, 1'b1},
    {OP_SUB,  8'h07, 8'h05, 1'b1, 8'h02, 1'b0},
    {OP_SUBC, 8'h05, 8'h05, 1'b1, 8'hFF, 1'b1},
    {OP_SUBC, 8'h06, 8'h05, 1'b1, 8'h00, 1'b0},
    {OP_SR0,  8'h81, 8'h00, 1'b0, 8'h40, 1'b1},
    {OP_SR1,  8'h02, 8'h00, 1'b0, 8'h81, 1'b0},
    {OP_SRX,  8'h80, 8'h00, 1'b0, 8'hC0, 1'b0},
    {OP_SRC,  8'h02, 8'h00, 1'b1, 8'h81, 1'b0},
    {OP_RR,   8'h01, 8'h00, 1'b0, 8'h80, 1'b1},
    {OP_SL0,  8'h81, 8'h00, 1'b0, 8'h02, 1'b1},
    {OP_SL1,  8'h40, 8'h00, 1'b0, 8'h81, 1'b0},
    {OP_SLX,  8'h01, 8'h00, 1'b0, 8'h03, 1'b0},
    {OP_SLC,  8'h80, 8'h00, 1'b1, 8'h01, 1'b1},
    {OP_RL,   8'h80, 8'h00, 1'b0, 8'h01, 1'b1},
    {OP_SR0,  8'h01, 8'h00, 1'b0, 8'h00, 1'b1}
  };

  function automatic string req_of(input logic [4:0] o);
    if (o == OP_LOAD) return "R3/R4";
    if (o <= OP_XOR)  return "R3/R5";
    if (o <= OP_ADDC) return "R6";
    if (o <= OP_SUBC) return "R7";
    if (o <= OP_RR)   return "R8";
    return "R9";
  endfunction

  // reference model from the requirements: {result, carry}
  function automatic logic [8:0] ref_op(input logic [4:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input logic c);
    logic [8:0] w;
    case (o)
      OP_LOAD: w = {y, c};
      OP_AND:  w = {x & y, 1'b0};
      OP_OR:   w = {x | y, 1'b0};
      OP_XOR:  w = {x ^ y, 1'b0};
      OP_ADD:  begin w = {1'b0, x} + {1'b0, y}; w = {w[7:0], w[8]}; end
      OP_ADDC: begin w = {1'b0, x} + {1'b0, y} + 9'(c); w = {w[7:0], w[8]}; end
      OP_SUB:  w = {x - y, (x < y)};
      OP_SUBC: w = {x - y - 8'(c), ({1'b0, x} < ({1'b0, y} + 9'(c)))};
      OP_SR0:  w = {1'b0, x[7:1], x[0]};
      OP_SR1:  w = {1'b1, x[7:1], x[0]};
      OP_SRX:  w = {x[7], x[7:1], x[0]};
      OP_SRC:  w = {c, x[7:1], x[0]};
      OP_RR:   w = {x[0], x[7:1], x[0]};
      OP_SL0:  w = {x[6:0], 1'b0, x[7]};
      OP_SL1:  w = {x[6:0], 1'b1, x[7]};
      OP_SLX:  w = {x[6:0], x[0], x[7]};
      OP_SLC:  w = {x[6:0], c, x[7]};
      default: w = {x[6:0], x[7], x[7]};
    endcase
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // SR1 of 0x01 -> carry 1, zero 0; SR0 of 0x00 -> carry 0, zero 1
  task automatic set_carry(input logic c);
    @(posedge clk); #1;
    op = c ? OP_SR1 : OP_SR0; a = c ? 8'h01 : 8'h00; flag_we = 1'b1;
    @(posedge clk); #1;
    flag_we = 1'b0;
  endtask

  task automatic run_op(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                        input logic c, input logic [7:0] er, input logic ec, input bit imm_sel);
    logic ez;
    set_carry(c);
    op = o; a = x; use_imm = imm_sel; flag_we = 1'b1;
    if (imm_sel) begin imm = y; reg_b = ~y; end else begin reg_b = y; imm = ~y; end
    #1;
    chk(result == er, req_of(o), result, er);
    chk(res_we, "R12", res_we, 1);
    ez = (o == OP_LOAD) ? !c : (er == 8'h00);
    @(posedge clk); #1;
    chk(carry == ec, req_of(o), carry, ec);
    chk(zero == ez, "R10", zero, ez);
    flag_we = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R2: reset state
    #3;
    chk(zero == 1'b0 && carry == 1'b0, "R2", {zero, carry}, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;

    foreach (VEC[i])
      run_op(VEC[i][30:26], VEC[i][25:18], VEC[i][17:10], VEC[i][9],
             VEC[i][8:1], VEC[i][0], i[0]);

    // R1: immediate against register select
    @(posedge clk); #1;
    op = OP_LOAD; reg_b = 8'h11; imm = 8'h99; use_imm = 1'b1; #1;
    chk(result == 8'h99, "R1", result, 8'h99);
    use_imm = 1'b0; #1;
    chk(result == 8'h11, "R1", result, 8'h11);
    chk(flag_we_out == 1'b0, "R4", flag_we_out, 0);

    // R11: flag enable low keeps flags
    set_carry(1'b1);
    op = OP_ADD; a = 8'h00; reg_b = 8'h00; flag_we = 1'b0;
    @(posedge clk); #1;
    chk(carry == 1'b1 && zero == 1'b0, "R11", {zero, carry}, 1);

    // R12: undefined codes write nothing
    for (int k = 18; k < 32; k++) begin
      op = 5'(k); a = 8'h00; flag_we = 1'b1; #1;
      chk(!res_we && !flag_we_out, "R12", {res_we, flag_we_out}, 0);
      @(posedge clk); #1;
      chk(carry == 1'b1 && zero == 1'b0, "R12", {zero, carry}, 1);
    end
    flag_we = 1'b0;

    // random sweep against reference model
    for (int n = 0; n < 300; n++) begin
      logic [4:0] ro;
      logic [7:0] ra, rb;
      logic       rc;
      logic [8:0] w;
      ro = 5'($urandom_range(0, 17));
      ra = 8'($urandom); rb = 8'($urandom); rc = 1'($urandom);
      w  = ref_op(ro, ra, rb, rc);
      run_op(ro, ra, rb, rc, w[8:1], w[0], 1'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule